// File: doc/BRIEF.md
# Input-Sync Phase Marker Overlay

This block sits in the output video path and paints a small diagnostic mark onto the picture. The mark shows where, inside the output raster, the vertical sync of the incoming video arrived, and its colour tells whether that sync came early, came late or was on time relative to the output frame. A user watching the display while the output timing is pulled toward the input timing can see the mark drift, change colour and settle.

The block receives the output raster's pixel and line counters. It also receives a single-cycle sync event that has already been moved into the output clock domain, and a two-bit phase code that some other logic produced. On each event it stores the current counter values and the phase code. From then on it draws a narrow rectangle, `DASH_W` pixels wide and `DASH_H` lines tall, whose top-left corner is the stored position. Every other pixel, and the horizontal sync, vertical sync and data-enable strobes, pass through one register stage so they stay aligned. A disable input makes the block a plain one-cycle delay.

Pixels are `PW` bits wide and packed as red in the top third, green in the middle third and blue in the bottom third.

Top module: `sync_dash_overlay`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pix_out`, `hs_out`, `vs_out` and `de_out` are zero, and no marker is drawn until the first `sync_evt` after reset.
- R2: Every output equals the matching input from one clock earlier (`pix_out` from `pix_in`, `hs_out` from `hs_in`, `vs_out` from `vs_in`, `de_out` from `de_in`), except for pixels that the marker replaces.
- R3: On a cycle with `sync_evt` high, the block stores `hcount`, `vcount` and `phase` as the marker's corner and colour code. That cycle's pixel is already treated with the new values, and the values are held unchanged until the next event.
- R4: A pixel is replaced only when `de_in` is high and both `(hcount - h0) mod 2^CW < DASH_W` and `(vcount - v0) mod 2^CW < DASH_H` hold, where (h0, v0) is the stored corner.
- R5: Phase code 2'b01 (input early) draws the marker in blue: blue field all ones, red and green fields zero.
- R6: Phase code 2'b10 (input late) draws the marker in red: red field all ones, green and blue fields zero.
- R7: Phase codes 2'b00 and 2'b11 (on time) draw the marker in green: green field all ones, red and blue fields zero.
- R8: While `en` is low, no pixel is replaced. Events are still stored, so a marker captured while disabled appears once `en` is high.
- R9: A later event replaces both the position and the colour of the marker, and nothing is drawn at the old position afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Overlay enable; low gives pure pass-through |
| hcount | input | CW | Output raster pixel counter |
| vcount | input | CW | Output raster line counter |
| sync_evt | input | 1 | One-cycle pulse: input vertical sync seen |
| phase | input | 2 | 00/11 on time, 01 early, 10 late |
| pix_in | input | PW | Incoming pixel, red-green-blue packed high to low |
| hs_in | input | 1 | Incoming horizontal sync |
| vs_in | input | 1 | Incoming vertical sync |
| de_in | input | 1 | Incoming data enable |
| pix_out | output | PW | Pixel with marker applied, one cycle late |
| hs_out | output | 1 | Horizontal sync delayed one cycle |
| vs_out | output | 1 | Vertical sync delayed one cycle |
| de_out | output | 1 | Data enable delayed one cycle |

## Verification
On every cycle the assertions check the one-cycle alignment of the sync and enable strobes and the untouched pass-through of pixels while disabled, during blanking and before any event has been seen. They also check that any replaced pixel carries one of the three marker colours. Only the bench's raster sweeps show that the rectangle lands at the exact stored corner with the right width and height, that the colour follows the stored phase code, and that a new event moves the mark. They also show that a position captured while disabled is kept, and that the edge of the active area clips the rectangle.

// File: rtl/sync_dash_overlay.sv
module sync_dash_overlay #(
  parameter int CW     = 12,
  parameter int PW     = 24,
  parameter int DASH_W = 4,
  parameter int DASH_H = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] vcount,
  input  logic          sync_evt,
  input  logic [1:0]    phase,
  input  logic [PW-1:0] pix_in,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          de_in,
  output logic [PW-1:0] pix_out,
  output logic          hs_out,
  output logic          vs_out,
  output logic          de_out
);
  localparam int CP = PW / 3;
  localparam logic [PW-1:0] BLUE  = PW'({CP{1'b1}});
  localparam logic [PW-1:0] GREEN = PW'({CP{1'b1}}) << CP;
  localparam logic [PW-1:0] RED   = PW'({CP{1'b1}}) << (2 * CP);

  logic [CW-1:0] h0, v0;
  logic [1:0]    code;
  logic          armed;

  wire [CW-1:0] h_ref  = sync_evt ? hcount : h0;
  wire [CW-1:0] v_ref  = sync_evt ? vcount : v0;
  wire [1:0]    c_ref  = sync_evt ? phase  : code;
  wire [CW-1:0] dh     = hcount - h_ref;
  wire [CW-1:0] dv     = vcount - v_ref;
  wire          in_box = (sync_evt || armed) && (dh < CW'(DASH_W)) && (dv < CW'(DASH_H));
  wire          paint  = en && de_in && in_box;

  logic [PW-1:0] mark;
  always_comb begin
    case (c_ref)
      2'b01:   mark = BLUE;
      2'b10:   mark = RED;
      default: mark = GREEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0 <= '0; v0 <= '0; code <= 2'b00; armed <= 1'b0;
    end else if (sync_evt) begin
      h0 <= hcount; v0 <= vcount; code <= phase; armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out <= '0; hs_out <= 1'b0; vs_out <= 1'b0; de_out <= 1'b0;
    end else begin
      pix_out <= paint ? mark : pix_in;
      hs_out  <= hs_in;
      vs_out  <= vs_in;
      de_out  <= de_in;
    end
  end
endmodule

module sync_dash_overlay_chk #(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sync_evt,
  input logic [PW-1:0] pix_in,
  input logic          hs_in,
  input logic          vs_in,
  input logic          de_in,
  input logic [PW-1:0] pix_out,
  input logic          hs_out,
  input logic          vs_out,
  input logic          de_out
);
  localparam int CP = PW / 3;
  localparam logic [PW-1:0] K_B = PW'({CP{1'b1}});
  localparam logic [PW-1:0] K_G = PW'({CP{1'b1}}) << CP;
  localparam logic [PW-1:0] K_R = PW'({CP{1'b1}}) << (2 * CP);

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (sync_evt) seen <= 1'b1;
  end

  a_r2_strobes_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hs_out == $past(hs_in)) && (vs_out == $past(vs_in)) && (de_out == $past(de_in)));

  a_r8_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> pix_out == $past(pix_in));

  a_r4_blanking_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(de_in)) |-> pix_out == $past(pix_in));

  a_r1_no_mark_before_event: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(seen) && !$past(sync_evt)) |-> pix_out == $past(pix_in));

  a_r5_marker_palette: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pix_out != $past(pix_in)) |-> (pix_out == K_B || pix_out == K_G || pix_out == K_R));
endmodule

bind sync_dash_overlay sync_dash_overlay_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sync_evt(sync_evt), .pix_in(pix_in),
  .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in), .pix_out(pix_out),
  .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
);

// File: tb/sim_sync_dash_overlay.sv
module sim_sync_dash_overlay;
  localparam int CW = 6, PW = 24, DW = 3, DH = 2;
  localparam int HT = 16, VT = 12, HA = 12, VA = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b1, sync_evt = 1'b0;
  logic [CW-1:0] hcount = '0, vcount = '0;
  logic [1:0] phase = 2'b00;
  logic [PW-1:0] pix_in = '0;
  logic hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [PW-1:0] pix_out;
  logic hs_out, vs_out, de_out;

  sync_dash_overlay #(.CW(CW), .PW(PW), .DASH_W(DW), .DASH_H(DH)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .hcount(hcount), .vcount(vcount),
    .sync_evt(sync_evt), .phase(phase), .pix_in(pix_in), .hs_in(hs_in),
    .vs_in(vs_in), .de_in(de_in), .pix_out(pix_out), .hs_out(hs_out),
    .vs_out(vs_out), .de_out(de_out));

  int total = 0, bad = 0;
  int m_h = 0, m_v = 0, m_c = 0;
  bit m_on = 1'b0, have = 1'b0;
  logic [PW-1:0] e_pix;
  logic [2:0] e_sync;
  string e_tag;

  function automatic logic [PW-1:0] colour(int c);
    if (c == 1) return 24'h0000FF;
    if (c == 2) return 24'hFF0000;
    return 24'h00FF00;
  endfunction

  task automatic check(string tag, logic [PW-1:0] ap, logic [PW-1:0] xp, logic [2:0] as, logic [2:0] xs);
    total++;
    if (ap !== xp || as !== xs) begin
      bad++;
      $display("FAIL %s pix=%h exp=%h hs/vs/de=%b exp=%b", tag, ap, xp, as, xs);
    end
  endtask

  task automatic frame(int eh, int ev, int ph, bit enable, string dtag);
    for (int v = 0; v < VT; v++) begin
      for (int h = 0; h < HT; h++) begin
        @(negedge clk);
        if (have) check(e_tag, pix_out, e_pix, {hs_out, vs_out, de_out}, e_sync);
        hcount = CW'(h); vcount = CW'(v); en = enable;
        de_in = (h < HA) && (v < VA);
        hs_in = (h >= 14); vs_in = (v >= 11);
        pix_in = {8'(h * 7 + 1), 8'(v * 13 + 2), 8'(h + v)};
        sync_evt = (h == eh) && (v == ev);
        phase = 2'(ph);
        if (sync_evt) begin m_h = h; m_v = v; m_c = ph; m_on = 1'b1; end
        e_sync = {hs_in, vs_in, de_in};
        if (m_on && enable && de_in && ((h - m_h) & 63) < DW && ((v - m_v) & 63) < DH) begin
          e_pix = colour(m_c);
          e_tag = (m_c == 1) ? "R5 early blue" : (m_c == 2) ? "R6 late red" : "R7 on-time green";
        end else begin
          e_pix = pix_in;
          e_tag = dtag;
        end
        have = 1'b1;
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", pix_out, '0, {hs_out, vs_out, de_out}, 3'b000);
        rst_n = 1'b1;
        frame(-1, -1, 1, 1'b1, "R1 no marker before event");
        frame(5, 3, 1, 1'b1, "R3 R4 corner capture and box");
        frame(-1, -1, 0, 1'b1, "R3 held until next event");
        frame(10, 8, 2, 1'b1, "R9 R4 move and clip at de edge");
        frame(2, 6, 0, 1'b0, "R8 disabled pass-through");
        frame(-1, -1, 1, 1'b1, "R8 captured while disabled");
        frame(7, 1, 3, 1'b1, "R7 R2 code 11 on time");
        frame(0, 0, 2, 1'b1, "R2 corner at origin");
        @(negedge clk);
        check(e_tag, pix_out, e_pix, {hs_out, vs_out, de_out}, e_sync);
      end
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule